// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two direction predictors. In the per-branch predictor, the branch PC selects a history register, and that register selects a 2-bit counter. In the path predictor, a single register that records the most recent outcomes selects a 2-bit counter. A table of 2-bit selector counters, indexed by the branch PC, decides which of the two predictions is used.

The fetch side presents a PC and reads back the final prediction and both component predictions in the same cycle. The component predictions travel down the pipeline with the branch. When the branch resolves, the resolve side presents the PC, the real outcome and the two component predictions that were given at fetch. In that cycle all three structures are trained.

Top module: `tourn_pred`

## Requirements
- R1: After reset, every history register (per-branch and path) holds zero. Every direction counter holds 1, which is weakly not-taken. Every selector entry holds 1, which selects the per-branch prediction. So all three prediction outputs are 0 for any PC.
- R2: Each direction counter counts up on a taken outcome and down on a not-taken outcome. It stops at 3 and at 0. Its bit 1 is its prediction.
- R3: The per-branch history entry selected by the PC shifts left on a valid resolve of that entry only. The new outcome enters at bit 0. The entry's value selects the per-branch counter whose bit 1 drives `pred_local_o`.
- R4: The path history shifts left on every valid resolve, with the outcome entering at bit 0. Its value selects the path counter whose bit 1 drives `pred_global_o`.
- R5: A selector value of 2 or 3 makes `pred_taken_o` follow the path prediction. A value of 0 or 1 makes it follow the per-branch prediction.
- R6: A selector entry changes only on a valid resolve in which `res_local_i` and `res_global_i` differ. It steps up, saturating at 3, when the path prediction matched the outcome. It steps down, saturating at 0, otherwise.
- R7: While `res_valid_i` is low, no history, counter or selector changes, whatever the other resolve inputs hold.
- R8: A resolve trains the per-branch counter selected by that branch's history before its shift. It trains the path counter selected by the path history before its shift. Predictions read in the cycle after the resolve reflect all updates.
- R9: The per-branch history and selector entries are selected by PC bits [PC_LSB+LIDX_W-1:PC_LSB]. PCs equal in those bits share entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | PC being fetched |
| pred_taken_o | output | 1 | Final direction prediction |
| pred_local_o | output | 1 | Per-branch component prediction |
| pred_global_o | output | 1 | Path component prediction |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | PC_W | PC of the resolved branch |
| res_taken_i | input | 1 | Actual outcome |
| res_local_i | input | 1 | Per-branch prediction given at fetch |
| res_global_i | input | 1 | Path prediction given at fetch |

## Verification
The bench builds the block with PC_W=16, LIDX_W=3, LHIST_W=3 and GHIST_W=4. This gives eight per-branch entries, eight per-branch counters and sixteen path counters. With tables this small, counter saturation, history wrap-around, PC aliasing and frequent disagreement between the two components all occur within a few hundred resolves. In a scenario of its own, the bench also drives component predictions on the resolve side that differ from what the block gave. This steers the selector through its whole range.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT  = 2'b01;
  localparam ctr_t CHS_WEAK_LOC = 2'b01;

  function automatic ctr_t ctr_next(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int   IDX_W = 10,
  parameter ctr_t INIT  = CTR_WEAK_NT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i,
  output ctr_t             wr_cur_o
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl_q [DEPTH];

  assign rd_o     = tbl_q[rd_idx_i];
  assign wr_cur_o = tbl_q[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= INIT;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= ctr_next(tbl_q[wr_idx_i], wr_up_i);
    end
  end
endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_bit_i,
  output logic [HIST_W-1:0] wr_cur_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  assign rd_o     = hist_q[rd_idx_i];
  assign wr_cur_o = hist_q[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en_i) begin
      hist_q[wr_idx_i] <= {hist_q[wr_idx_i][HIST_W-2:0], wr_bit_i};
    end
  end
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GHIST_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_taken_o,
  output logic            pred_local_o,
  output logic            pred_global_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i,
  input  logic            res_local_i,
  input  logic            res_global_i
);
  logic [LIDX_W-1:0]  f_idx, r_idx;
  logic [LHIST_W-1:0] f_lhist, r_lhist;
  logic [GHIST_W-1:0] ghr_q;
  ctr_t f_lctr, f_gctr, f_chs, r_chs;
  ctr_t unused_lcur, unused_gcur;
  logic unused_pc;
  logic chs_wr;

  assign f_idx     = fetch_pc_i[PC_LSB +: LIDX_W];
  assign r_idx     = res_pc_i[PC_LSB +: LIDX_W];
  assign unused_pc = ^{fetch_pc_i, res_pc_i, unused_lcur, unused_gcur};

  // only train the selector when the components disagreed
  assign chs_wr = res_valid_i && (res_local_i != res_global_i);

  tp_local_hist #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (f_idx),
    .rd_o     (f_lhist),
    .wr_en_i  (res_valid_i),
    .wr_idx_i (r_idx),
    .wr_bit_i (res_taken_i),
    .wr_cur_o (r_lhist)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WEAK_NT)) u_lct (
    .clk_i, .rst_ni,
    .rd_idx_i (f_lhist),
    .rd_o     (f_lctr),
    .wr_en_i  (res_valid_i),
    .wr_idx_i (r_lhist),
    .wr_up_i  (res_taken_i),
    .wr_cur_o (unused_lcur)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_NT)) u_gct (
    .clk_i, .rst_ni,
    .rd_idx_i (ghr_q),
    .rd_o     (f_gctr),
    .wr_en_i  (res_valid_i),
    .wr_idx_i (ghr_q),
    .wr_up_i  (res_taken_i),
    .wr_cur_o (unused_gcur)
  );

  tp_ctr_table #(.IDX_W(LIDX_W), .INIT(CHS_WEAK_LOC)) u_chs (
    .clk_i, .rst_ni,
    .rd_idx_i (f_idx),
    .rd_o     (f_chs),
    .wr_en_i  (chs_wr),
    .wr_idx_i (r_idx),
    .wr_up_i  (res_global_i == res_taken_i),
    .wr_cur_o (r_chs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghr_q <= '0;
    else if (res_valid_i) ghr_q <= {ghr_q[GHIST_W-2:0], res_taken_i};
  end

  assign pred_local_o  = f_lctr[1];
  assign pred_global_o = f_gctr[1];
  assign pred_taken_o  = f_chs[1] ? pred_global_o : pred_local_o;
endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
  parameter int PC_W    = 32,
  parameter int GHIST_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pred_taken_i,
  input logic               pred_local_i,
  input logic               pred_global_i,
  input logic               res_valid_i,
  input logic [PC_W-1:0]    res_pc_i,
  input logic               res_taken_i,
  input logic               res_local_i,
  input logic               res_global_i,
  input logic [GHIST_W-1:0] ghr_i,
  input logic [1:0]         chs_i
);
  // R5
  agree_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_local_i == pred_global_i) |-> (pred_taken_i == pred_local_i));

  // R4
  ghr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |=> (ghr_i == {$past(ghr_i[GHIST_W-2:0]), $past(res_taken_i)}));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(ghr_i));

  // R6
  chs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!res_valid_i || (res_local_i == res_global_i)) && $stable(res_pc_i))
      |-> $stable(chs_i));

  // R6
  chs_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_valid_i && (res_local_i != res_global_i) && (res_global_i == res_taken_i))
      && $stable(res_pc_i))
      |-> (chs_i == (($past(chs_i) == 2'd3) ? 2'd3 : $past(chs_i) + 2'd1)));

  // R6
  chs_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(res_valid_i && (res_local_i != res_global_i) && (res_local_i == res_taken_i))
      && $stable(res_pc_i))
      |-> (chs_i == (($past(chs_i) == 2'd0) ? 2'd0 : $past(chs_i) - 2'd1)));
endmodule

bind tourn_pred tourn_pred_chk #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pred_taken_i  (pred_taken_o),
  .pred_local_i  (pred_local_o),
  .pred_global_i (pred_global_o),
  .res_valid_i   (res_valid_i),
  .res_pc_i      (res_pc_i),
  .res_taken_i   (res_taken_i),
  .res_local_i   (res_local_i),
  .res_global_i  (res_global_i),
  .ghr_i         (ghr_q),
  .chs_i         (r_chs)
);

// File: tb/sim_tourn_pred.sv
`timescale 1ns/1ps
module sim_tourn_pred;
  localparam int PC_W = 16, PC_LSB = 2, LIDX_W = 3, LHIST_W = 3, GHIST_W = 4;
  localparam int NL = 1 << LIDX_W, NH = 1 << LHIST_W, NG = 1 << GHIST_W;

  logic clk_i = 0, rst_ni = 0;
  logic [PC_W-1:0] fetch_pc_i = '0, res_pc_i = '0;
  logic res_valid_i = 0, res_taken_i = 0, res_local_i = 0, res_global_i = 0;
  logic pred_taken_o, pred_local_o, pred_global_o;

  int n_chk = 0, n_bad = 0;
  int m_lh [NL], m_ch [NL], m_lct [NH], m_gct [NG];
  int m_ghr = 0;

  always #4 clk_i = ~clk_i;

  tourn_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LIDX_W(LIDX_W),
               .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)) u0 (.*);

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'((pc >> PC_LSB) & (NL - 1));
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  // drive fetch pc and compare the three outputs with the model
  task automatic peek(logic [PC_W-1:0] pc, string tag, output bit el, output bit eg);
    int li;
    bit et;
    fetch_pc_i = pc;
    #1;
    li = idx_of(pc);
    el = m_lct[m_lh[li]][1];
    eg = m_gct[m_ghr][1];
    et = (m_ch[li] >= 2) ? eg : el;
    chk(tag, "pred_local", pred_local_o, el);
    chk(tag, "pred_global", pred_global_o, eg);
    chk(tag, "pred_taken", pred_taken_o, et);
  endtask

  task automatic branch(logic [PC_W-1:0] pc, bit t, bit frc, bit fl, bit fg, string tag);
    bit el, eg, l, g;
    int li, lh;
    peek(pc, tag, el, eg);
    l = frc ? fl : el;
    g = frc ? fg : eg;
    res_pc_i = pc; res_taken_i = t; res_local_i = l; res_global_i = g; res_valid_i = 1;
    @(posedge clk_i);
    li = idx_of(pc);
    lh = m_lh[li];
    m_lct[lh] = sat(m_lct[lh], t);
    m_gct[m_ghr] = sat(m_gct[m_ghr], t);
    if (l != g) m_ch[li] = sat(m_ch[li], g == t);
    m_lh[li] = ((lh << 1) | int'(t)) & (NH - 1);
    m_ghr = ((m_ghr << 1) | int'(t)) & (NG - 1);
    @(negedge clk_i);
    res_valid_i = 0;
  endtask

  task automatic t_reset;
    bit a, b;
    for (int i = 0; i < NL; i++) begin
      peek(PC_W'(i << PC_LSB), "R1", a, b);
      chk("R1", "reset_taken", pred_taken_o, 1'b0);
    end
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 6; i++) branch(16'h0004, 1, 0, 0, 0, "R2");
    branch(16'h0004, 0, 0, 0, 0, "R2");
    branch(16'h0004, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) branch(16'h0004, 0, 0, 0, 0, "R2");
  endtask

  task automatic t_local_pattern;
    for (int k = 0; k < 10; k++) begin
      branch(16'h0008, 1, 0, 0, 0, "R3");
      branch(16'h0008, 1, 0, 0, 0, "R3");
      branch(16'h0008, 0, 0, 0, 0, "R3");
    end
  endtask

  task automatic t_global_corr;
    for (int k = 0; k < 12; k++) begin
      bit o = k[0];
      branch(16'h000C, o, 0, 0, 0, "R4");
      branch(16'h0010, !o, 0, 0, 0, "R8");
    end
  endtask

  task automatic t_chooser;
    // global right, local wrong: selector climbs and saturates
    for (int i = 0; i < 4; i++) branch(16'h0014, 1, 1, 0, 1, "R6");
    // agreement leaves selector alone
    for (int i = 0; i < 3; i++) branch(16'h0014, 0, 1, 1, 1, "R6");
    // local right: selector falls to bottom
    for (int i = 0; i < 5; i++) branch(16'h0014, 0, 1, 0, 1, "R5");
    for (int i = 0; i < 2; i++) branch(16'h0014, 1, 1, 0, 1, "R5");
  endtask

  task automatic t_idle;
    bit a, b;
    res_valid_i = 0;
    for (int i = 0; i < 5; i++) begin
      res_pc_i = PC_W'(i * 4); res_taken_i = 1; res_local_i = i[0]; res_global_i = !i[0];
      @(negedge clk_i);
    end
    for (int i = 0; i < NL; i++) peek(PC_W'(i << PC_LSB), "R7", a, b);
  endtask

  task automatic t_alias;
    bit a, b;
    for (int i = 0; i < 4; i++) branch(16'h0018 | 16'h0100, 1, 0, 0, 0, "R9");
    peek(16'h0018, "R9", a, b);
    peek(16'h0418, "R9", a, b);
  endtask

  task automatic t_mix;
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [PC_W-1:0] pc;
      bit t;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pc = {8'h00, lf[7:2], 2'b00};
      t = lf[4] ? (lf[10:9] != 2'b00) : (lf[10] & lf[11]);
      branch(pc, t, 0, 0, 0, "R8");
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_lh[i] = 0; m_ch[i] = 1; end
    for (int i = 0; i < NH; i++) m_lct[i] = 1;
    for (int i = 0; i < NG; i++) m_gct[i] = 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_saturate();
    t_local_pattern();
    t_global_corr();
    t_chooser();
    t_idle();
    t_alias();
    t_mix();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule